// File: doc/BRIEF.md
# Keccak-256 Sponge Absorb and Squeeze Controller

This block runs the sponge flow around an external 1600-bit Keccak permutation. It keeps the sponge state in its own register. Each padded block arrives on a rate-wide bus, 1088 bits wide. The block XORs it into the low rate bits of the state and sends the updated state to the permutation with a one-cycle start pulse. It then waits for the permutation's done flag and takes the permuted state back as the new sponge state. Padding is done upstream, and the round function sits in a separate block.

When the permuted result of a block marked last comes back, the low 256 bits of that result are captured as the digest, and a ready flag goes high. The flag stays high until reset, or until the first block of the next message arrives. That block is absorbed into an all-zero state, so messages never leak into each other. All handshake inputs are sampled on the rising clock edge. Every output comes straight from a register.

State bit 64*(5y+x)+z is bit z of lane (x,y). Block bit i lands on state bit i, so lanes are little-endian in byte order.

Top module: `sponge_core`

## Requirements
- R1: After synchronous reset (`rst` high at a rising edge), `perm_state` is all zeros, `digest` is zero, and `perm_start` and `out_ready` are low.
- R2: A block accepted with `blk_valid` high while the controller is not waiting on the permutation sets `perm_state[1087:0]` to the old state XOR `blk_data`. `perm_state[1599:1088]` is left unchanged. The new value is visible after that clock edge.
- R3: `perm_start` is high for exactly the one cycle after each accepted block, and is low at all other times.
- R4: While a permutation is outstanding (from the start pulse until `perm_done` is sampled), `blk_valid` is ignored: no start pulse follows it and `perm_state` does not change.
- R5: `perm_done` sampled while a permutation is outstanding loads `perm_result` into the state. `perm_done` sampled at any other time has no effect on `perm_state` or `digest`.
- R6: When the permutation of a block flagged with `blk_last` completes, `digest` becomes `perm_result[255:0]` and `out_ready` rises in the same cycle.
- R7: `out_ready` and `digest` hold until reset or a new block. A block accepted while `out_ready` is high drops `out_ready` and is absorbed into an all-zero state: `perm_state` becomes `blk_data` zero-extended.
- R8: Completion of a block that is not flagged last leaves `out_ready` low and returns the controller to accepting blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_valid | input | 1 | A padded block is present on `blk_data` |
| blk_last | input | 1 | The present block is the final block of the message |
| blk_data | input | 1088 | Padded rate block, bit i goes to state bit i |
| perm_done | input | 1 | The permutation has finished; `perm_result` is valid |
| perm_result | input | 1600 | Permuted state returned by the round logic |
| perm_start | output | 1 | One-cycle request to permute `perm_state` |
| perm_state | output | 1600 | Current sponge state, fed to the permutation |
| digest | output | 256 | Truncated hash output |
| out_ready | output | 1 | `digest` holds the hash of the last message |

## Verification
The bound checker watches several rules on every cycle:
- the start pulse lasts one cycle and only follows a block strobe;
- no start and no state change happen while a permutation is outstanding;
- a stray done flag never moves the state;
- the capacity lanes survive an absorb, or are zero on the first absorb after a digest;
- the ready flag and the digest hold until the next block.

The bench's scenarios cover what needs a reference model. They check the exact XOR of each rate block into the running state across messages of one to four blocks with several data patterns. They check that the digest equals the low 256 bits of the final permuted state. They also check the restart from zero after a finished message, and reset in the middle of a message.

// File: rtl/sponge_pkg.sv
`timescale 1ns/1ps
package sponge_pkg;

    localparam int LANE_W       = 64;
    localparam int STATE_W_DEF  = 1600;
    localparam int RATE_W_DEF   = 1088;
    localparam int DIGEST_W_DEF = 256;

    // Controller phase: accepting blocks, waiting on the permutation,
    // or holding a finished digest.
    typedef enum logic [1:0] {
        PH_ACCEPT  = 2'd0,
        PH_PERMUTE = 2'd1,
        PH_DIGEST  = 2'd2
    } phase_e;

    // Per-cycle command from the controller to the datapath.
    typedef struct packed {
        logic absorb;   // XOR a block into the rate lanes
        logic clear;    // start from a zero state (new message)
        logic load;     // take the permutation result
        logic publish;  // capture the digest from the result
    } cmd_t;

    // New lane value on absorb: fresh messages start from zero.
    function automatic logic [LANE_W-1:0] lane_absorb(
        input logic [LANE_W-1:0] cur,
        input logic [LANE_W-1:0] blk,
        input logic              fresh
    );
        return fresh ? blk : (cur ^ blk);
    endfunction

    function automatic int lane_count(input int bits);
        return bits / LANE_W;
    endfunction

endpackage

// File: rtl/sponge_ctrl.sv
`timescale 1ns/1ps
module sponge_ctrl
    import sponge_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic blk_valid,
    input  logic blk_last,
    input  logic perm_done,
    output cmd_t cmd,
    output logic perm_start,
    output logic out_ready
);

    phase_e phase_q;
    logic   last_q;
    logic   accepting;

    // Blocks are taken only outside a permutation.
    assign accepting   = (phase_q == PH_ACCEPT) || (phase_q == PH_DIGEST);
    assign cmd.absorb  = accepting && blk_valid;
    assign cmd.clear   = (phase_q == PH_DIGEST) && blk_valid;
    assign cmd.load    = (phase_q == PH_PERMUTE) && perm_done;
    assign cmd.publish = cmd.load && last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_ACCEPT;
            last_q     <= 1'b0;
            perm_start <= 1'b0;
            out_ready  <= 1'b0;
        end else begin
            perm_start <= cmd.absorb;
            if (cmd.absorb) begin
                phase_q   <= PH_PERMUTE;
                last_q    <= blk_last;
                out_ready <= 1'b0;
            end else if (cmd.load) begin
                phase_q   <= last_q ? PH_DIGEST : PH_ACCEPT;
                out_ready <= last_q;
            end
        end
    end

endmodule

// File: rtl/sponge_state.sv
`timescale 1ns/1ps
module sponge_state
    import sponge_pkg::*;
#(
    parameter int STATE_W = STATE_W_DEF,
    parameter int RATE_W  = RATE_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  cmd_t               cmd,
    input  logic [RATE_W-1:0]  blk_data,
    input  logic [STATE_W-1:0] perm_result,
    output logic [STATE_W-1:0] state_q
);

    localparam int NUM_LANES  = lane_count(STATE_W);
    localparam int RATE_LANES = lane_count(RATE_W);

    logic [STATE_W-1:0] state_d;

    // One next-state mux per lane; rate lanes absorb, capacity lanes
    // only clear or reload.
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        localparam int LO = l * LANE_W;
        logic [LANE_W-1:0] cur;
        logic [LANE_W-1:0] res;
        logic [LANE_W-1:0] nxt;
        assign cur = state_q[LO +: LANE_W];
        assign res = perm_result[LO +: LANE_W];
        if (l < RATE_LANES) begin : g_rate
            logic [LANE_W-1:0] blk;
            assign blk = blk_data[LO +: LANE_W];
            always_comb begin
                if (cmd.load)
                    nxt = res;
                else if (cmd.absorb)
                    nxt = lane_absorb(cur, blk, cmd.clear);
                else
                    nxt = cur;
            end
        end else begin : g_cap
            always_comb begin
                if (cmd.load)
                    nxt = res;
                else if (cmd.absorb && cmd.clear)
                    nxt = '0;
                else
                    nxt = cur;
            end
        end
        assign state_d[LO +: LANE_W] = nxt;
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= '0;
        else
            state_q <= state_d;
    end

endmodule

// File: rtl/sponge_digest.sv
`timescale 1ns/1ps
module sponge_digest
    import sponge_pkg::*;
#(
    parameter int DIGEST_W = DIGEST_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  cmd_t                cmd,
    input  logic [DIGEST_W-1:0] trunc_src,
    output logic [DIGEST_W-1:0] digest_q
);

    always_ff @(posedge clk) begin
        if (rst)
            digest_q <= '0;
        else if (cmd.publish)
            digest_q <= trunc_src;
    end

endmodule

// File: rtl/sponge_core.sv
`timescale 1ns/1ps
module sponge_core
    import sponge_pkg::*;
#(
    parameter int STATE_W  = STATE_W_DEF,
    parameter int RATE_W   = RATE_W_DEF,
    parameter int DIGEST_W = DIGEST_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                blk_valid,
    input  logic                blk_last,
    input  logic [RATE_W-1:0]   blk_data,
    input  logic                perm_done,
    input  logic [STATE_W-1:0]  perm_result,
    output logic                perm_start,
    output logic [STATE_W-1:0]  perm_state,
    output logic [DIGEST_W-1:0] digest,
    output logic                out_ready
);

    cmd_t cmd;

    sponge_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .blk_valid  (blk_valid),
        .blk_last   (blk_last),
        .perm_done  (perm_done),
        .cmd        (cmd),
        .perm_start (perm_start),
        .out_ready  (out_ready)
    );

    sponge_state #(
        .STATE_W (STATE_W),
        .RATE_W  (RATE_W)
    ) u_state (
        .clk         (clk),
        .rst         (rst),
        .cmd         (cmd),
        .blk_data    (blk_data),
        .perm_result (perm_result),
        .state_q     (perm_state)
    );

    sponge_digest #(
        .DIGEST_W (DIGEST_W)
    ) u_digest (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .trunc_src (perm_result[DIGEST_W-1:0]),
        .digest_q  (digest)
    );

endmodule

// File: rtl/sponge_checker.sv
`timescale 1ns/1ps
module sponge_checker #(
    parameter int STATE_W  = 1600,
    parameter int RATE_W   = 1088,
    parameter int DIGEST_W = 256
) (
    input logic                clk,
    input logic                rst,
    input logic                blk_valid,
    input logic                perm_done,
    input logic                perm_start,
    input logic [STATE_W-1:0]  perm_state,
    input logic [DIGEST_W-1:0] digest,
    input logic                out_ready
);

    // Outstanding permutation, rebuilt from the handshake ports only.
    logic busy_q;
    logic waiting;
    assign waiting = busy_q || perm_start;

    always_ff @(posedge clk) begin
        if (rst)
            busy_q <= 1'b0;
        else
            busy_q <= waiting && !perm_done;
    end

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        perm_start |=> !perm_start); // R3

    AST_START_NEEDS_BLOCK: assert property (@(posedge clk) disable iff (rst)
        perm_start |-> $past(blk_valid)); // R3

    AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (rst)
        (waiting && blk_valid) |=> !perm_start); // R4

    AST_BUSY_STATE_HELD: assert property (@(posedge clk) disable iff (rst)
        (waiting && !perm_done) |=> $stable(perm_state)); // R4

    AST_STRAY_DONE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!waiting && !blk_valid) |=> $stable(perm_state)); // R5

    AST_CAPACITY_KEPT: assert property (@(posedge clk) disable iff (rst)
        (perm_start && !$past(out_ready)) |->
            perm_state[STATE_W-1:RATE_W] == $past(perm_state[STATE_W-1:RATE_W])); // R2

    AST_FRESH_CAPACITY_ZERO: assert property (@(posedge clk) disable iff (rst)
        (perm_start && $past(out_ready)) |-> perm_state[STATE_W-1:RATE_W] == '0); // R7

    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (out_ready && !blk_valid) |=> out_ready); // R7

    AST_DIGEST_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (out_ready && !blk_valid) |=> $stable(digest)); // R7

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
        (out_ready && blk_valid) |=> (!out_ready && perm_start)); // R7

    AST_READY_ONLY_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(out_ready) |-> $past(perm_done)); // R6

endmodule

bind sponge_core sponge_checker #(
    .STATE_W  (STATE_W),
    .RATE_W   (RATE_W),
    .DIGEST_W (DIGEST_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .blk_valid  (blk_valid),
    .perm_done  (perm_done),
    .perm_start (perm_start),
    .perm_state (perm_state),
    .digest     (digest),
    .out_ready  (out_ready)
);

// File: tb/sponge_core_tb.sv
`timescale 1ns/1ps
module sponge_core_tb;

    localparam int STATE_W  = 1600;
    localparam int RATE_W   = 1088;
    localparam int DIGEST_W = 256;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                blk_valid = 1'b0;
    logic                blk_last = 1'b0;
    logic [RATE_W-1:0]   blk_data = '0;
    logic                perm_done = 1'b0;
    logic [STATE_W-1:0]  perm_result = '0;
    logic                perm_start;
    logic [STATE_W-1:0]  perm_state;
    logic [DIGEST_W-1:0] digest;
    logic                out_ready;

    int checks = 0;
    int failures = 0;

    logic [STATE_W-1:0] m_state = '0;
    logic               m_fresh = 1'b0;

    always #5 clk = ~clk;

    sponge_core u_dut (
        .clk         (clk),
        .rst         (rst),
        .blk_valid   (blk_valid),
        .blk_last    (blk_last),
        .blk_data    (blk_data),
        .perm_done   (perm_done),
        .perm_result (perm_result),
        .perm_start  (perm_start),
        .perm_state  (perm_state),
        .digest      (digest),
        .out_ready   (out_ready)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [STATE_W-1:0] act,
                         input logic [STATE_W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Stand-in permutation: rotate left by 7 and XOR a lane constant.
    function automatic logic [STATE_W-1:0] mix(input logic [STATE_W-1:0] s);
        logic [STATE_W-1:0] r;
        r = {s[STATE_W-8:0], s[STATE_W-1:STATE_W-7]};
        return r ^ {25{64'hC3A5_5A3C_0F96_E187}};
    endfunction

    function automatic logic [RATE_W-1:0] pat(input int seed, input int k);
        logic [RATE_W-1:0] r;
        if (seed == 0) return '1;
        for (int j = 0; j < RATE_W / 64; j++) begin
            logic [63:0] w;
            w = (64'h9E37_79B9_7F4A_7C15 * 64'(seed * 8 + k + 1))
                ^ (64'(j) << 40) ^ 64'(j * 3 + k);
            r[j*64 +: 64] = w;
        end
        return r;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        blk_valid = 1'b0;
        perm_done = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_state = '0;
        m_fresh = 1'b0;
        check(perm_state == '0, "R1 state", perm_state, '0);
        check(digest == '0, "R1 digest", STATE_W'(digest), '0);
        check(!perm_start && !out_ready, "R1 flags",
              STATE_W'({perm_start, out_ready}), '0);
    endtask

    task automatic absorb(input logic [RATE_W-1:0] blk, input bit last);
        logic [STATE_W-1:0] exp;
        logic [DIGEST_W-1:0] dig_before;
        bit fresh;
        @(negedge clk);
        fresh = m_fresh;
        exp = (fresh ? '0 : m_state) ^ STATE_W'(blk);
        blk_valid = 1'b1;
        blk_data  = blk;
        blk_last  = last;
        @(negedge clk);
        blk_valid = 1'b0;
        check(perm_start == 1'b1, "R3 start pulse", STATE_W'(perm_start), 1);
        if (fresh) begin
            check(perm_state == exp, "R7 fresh absorb", perm_state, exp);
            check(out_ready == 1'b0, "R7 ready drop", STATE_W'(out_ready), 0);
        end else begin
            check(perm_state == exp, "R2 absorb xor", perm_state, exp);
        end
        m_state = exp;
        m_fresh = 1'b0;
        // R4: a block strobe while the permutation is outstanding
        blk_valid = 1'b1;
        blk_data  = ~blk;
        @(negedge clk);
        blk_valid = 1'b0;
        check(perm_start == 1'b0, "R3 start low", STATE_W'(perm_start), 0);
        @(negedge clk);
        check(perm_start == 1'b0, "R4 no start when busy", STATE_W'(perm_start), 0);
        check(perm_state == m_state, "R4 state held", perm_state, m_state);
        dig_before = digest;
        perm_done   = 1'b1;
        perm_result = mix(m_state);
        @(negedge clk);
        perm_done = 1'b0;
        m_state = mix(m_state);
        check(perm_state == m_state, "R5 load result", perm_state, m_state);
        if (last) begin
            check(out_ready == 1'b1, "R6 ready", STATE_W'(out_ready), 1);
            check(digest == m_state[DIGEST_W-1:0], "R6 digest",
                  STATE_W'(digest), STATE_W'(m_state[DIGEST_W-1:0]));
            m_fresh = 1'b1;
        end else begin
            check(out_ready == 1'b0, "R8 no ready", STATE_W'(out_ready), 0);
            check(digest == dig_before, "R8 digest kept",
                  STATE_W'(digest), STATE_W'(dig_before));
        end
    endtask

    task automatic stray_done();
        logic [STATE_W-1:0] keep_s;
        logic [DIGEST_W-1:0] keep_d;
        @(negedge clk);
        keep_s = perm_state;
        keep_d = digest;
        perm_done   = 1'b1;
        perm_result = ~m_state;
        @(negedge clk);
        perm_done = 1'b0;
        check(perm_state == keep_s, "R5 stray done state", perm_state, keep_s);
        check(digest == keep_d, "R5 stray done digest",
              STATE_W'(digest), STATE_W'(keep_d));
    endtask

    task automatic hold(input int n);
        logic [DIGEST_W-1:0] keep_d;
        keep_d = digest;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(out_ready == 1'b1, "R7 ready holds", STATE_W'(out_ready), 1);
            check(digest == keep_d, "R7 digest holds",
                  STATE_W'(digest), STATE_W'(keep_d));
        end
    endtask

    initial begin
        #(10 * 200000);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        for (int seed = 0; seed < 3; seed++) begin
            for (int len = 1; len <= 4; len++) begin
                for (int k = 0; k < len; k++) begin
                    absorb(pat(seed, k + len), k == len - 1);
                    if (k != len - 1) stray_done();
                end
                stray_done();
                hold(3);
            end
        end
        // Reset in the middle of a message, with a permutation outstanding
        absorb(pat(5, 1), 1'b0);
        @(negedge clk);
        blk_valid = 1'b1;
        blk_data  = pat(6, 2);
        blk_last  = 1'b0;
        @(negedge clk);
        blk_valid = 1'b0;
        do_reset();
        absorb(pat(7, 3), 1'b1);
        hold(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule